// File: doc/BRIEF.md
# Delay-Feedback Radix-2 Butterfly with Trivial −j Rotation

This block is the second butterfly of a radix-2² single-path delay-feedback FFT stage pair. A complex sample arrives every clock. A feedback delay line of `DLY_LEN` entries (N/4 for an N-point transform) pairs each sample with the one that came `DLY_LEN` cycles earlier. While the butterfly-mode bit is low, new samples are written into the line and the line's oldest entry goes to the output. While it is high, the oldest entry and the new sample are added and subtracted. The sum goes to the output and the difference goes back into the line, so it leaves the block during the next load phase.

When both the butterfly-mode bit and the rotate-enable bit are high, the incoming sample is multiplied by −j before the add/subtract. No multiplier is used. The imaginary part becomes the new real part, and the negated real part becomes the new imaginary part. The real part is sign-extended by one bit before it is negated, so the most negative input value stays exact. Both control bits come from the shared frame counter of the stage pair. Outputs are one bit wider than the inputs, and the latency is `DLY_LEN` cycles.

Top module: `sdf_rot_bfly`

## Requirements
- R1: While `bf_sel` is 0, the output equals (a − x') for the pair completed `DLY_LEN` cycles earlier. Here a is the sample loaded in the phase before that, and x' is its partner after any rotation. The value is exact in `DATA_W+1` bits.
- R2: While `bf_sel` is 1, the output equals a + x'. Here a is the unrotated sample that entered exactly `DLY_LEN` cycles earlier, and x' is the current sample after any rotation.
- R3: When `bf_sel` and `rot_sel` are both 1, x' = Im(x) − j·Re(x). Otherwise x' = x.
- R4: `rot_sel` has no effect while `bf_sel` is 0. Samples are stored unrotated.
- R5: Rotating a sample whose real part is −2^(DATA_W−1) gives an imaginary part of +2^(DATA_W−1), with no wrap.
- R6: No sum or difference overflows `DATA_W+1` signed bits for any input values, including the full-scale extremes.
- R7: The sum of a pair appears in the same cycle as the pair's second sample arrives. That is `DLY_LEN` cycles after the first sample.
- R8: After reset the delay line holds zeros. The outputs are 0 during a load phase until the line has been refilled. `rst_n` asserts asynchronously and releases through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bf_sel | input | 1 | Butterfly mode: 0 load/drain, 1 add/subtract |
| rot_sel | input | 1 | Rotate enable. Applies −j when `bf_sel` is also 1 |
| din_re | input | DATA_W | Input real part, two's complement |
| din_im | input | DATA_W | Input imaginary part, two's complement |
| dout_re | output | DATA_W+1 | Output real part, two's complement |
| dout_im | output | DATA_W+1 | Output imaginary part, two's complement |

## Verification
A wrong entry in the delay line shows up at the ports within `DLY_LEN` cycles. In the butterfly phase it corrupts the sum at once. In the next load phase it corrupts the drained difference. A rotation fault, such as a missed swap, a wrong sign, or a lost sign bit on the most negative value, shows in the sum in the same cycle. It shows again in the difference `DLY_LEN` cycles later. The bench therefore compares every output cycle with a model built from the input history. That model covers stimulus with full-scale extremes and a `rot_sel` that changes at random during load phases.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_BFLY = 1'b1
  } srb_phase_e;
endpackage

// File: rtl/srb_rst_sync.sv
module srb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stg1_q;
  logic stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign srst_n = stg2_q;
endmodule

// File: rtl/srb_rotate.sv
module srb_rotate #(
  parameter int DATA_W = 12,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  input  logic              rot_en,
  output logic [EXT_W-1:0]  out_re,
  output logic [EXT_W-1:0]  out_im
);
  logic [EXT_W-1:0] ext_re;
  logic [EXT_W-1:0] ext_im;

  // widen first so that negating the most negative value is exact
  assign ext_re = {in_re[DATA_W-1], in_re};
  assign ext_im = {in_im[DATA_W-1], in_im};

  always_comb begin
    if (rot_en) begin
      out_re = ext_im;
      out_im = EXT_W'(0) - ext_re;
    end else begin
      out_re = ext_re;
      out_im = ext_im;
    end
  end
endmodule

// File: rtl/srb_addsub.sv
module srb_addsub
  import srb_pkg::*;
#(
  parameter int VAL_W = 13
) (
  input  logic             clk,
  input  logic             srst_n,
  input  srb_phase_e       phase,
  input  logic [VAL_W-1:0] old_re,
  input  logic [VAL_W-1:0] old_im,
  input  logic [VAL_W-1:0] new_re,
  input  logic [VAL_W-1:0] new_im,
  output logic [VAL_W-1:0] out_re,
  output logic [VAL_W-1:0] out_im,
  output logic [VAL_W-1:0] fb_re,
  output logic [VAL_W-1:0] fb_im
);
  localparam int WIDE_W = VAL_W + 1;

  logic [WIDE_W-1:0] sum_re;
  logic [WIDE_W-1:0] sum_im;
  logic [WIDE_W-1:0] dif_re;
  logic [WIDE_W-1:0] dif_im;

  assign sum_re = {old_re[VAL_W-1], old_re} + {new_re[VAL_W-1], new_re};
  assign sum_im = {old_im[VAL_W-1], old_im} + {new_im[VAL_W-1], new_im};
  assign dif_re = {old_re[VAL_W-1], old_re} - {new_re[VAL_W-1], new_re};
  assign dif_im = {old_im[VAL_W-1], old_im} - {new_im[VAL_W-1], new_im};

  always_comb begin
    if (phase == PH_BFLY) begin
      out_re = sum_re[VAL_W-1:0];
      out_im = sum_im[VAL_W-1:0];
      fb_re  = dif_re[VAL_W-1:0];
      fb_im  = dif_im[VAL_W-1:0];
    end else begin
      out_re = old_re;
      out_im = old_im;
      fb_re  = new_re;
      fb_im  = new_im;
    end
  end

  // R6: only the incoming operand is ever rotated, so the extra bit is never needed
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (phase == PH_BFLY) |->
      (sum_re[VAL_W] == sum_re[VAL_W-1]) && (sum_im[VAL_W] == sum_im[VAL_W-1]) &&
      (dif_re[VAL_W] == dif_re[VAL_W-1]) && (dif_im[VAL_W] == dif_im[VAL_W-1]));
endmodule

// File: rtl/srb_delay.sv
module srb_delay #(
  parameter int VAL_W = 13,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [VAL_W-1:0] wr_re,
  input  logic [VAL_W-1:0] wr_im,
  output logic [VAL_W-1:0] head_re,
  output logic [VAL_W-1:0] head_im
);
  logic [VAL_W-1:0] tap_re_q [DEPTH];
  logic [VAL_W-1:0] tap_im_q [DEPTH];
  logic [VAL_W-1:0] tap_re_d [DEPTH];
  logic [VAL_W-1:0] tap_im_d [DEPTH];
  logic             shift_en;

  assign shift_en = 1'b1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_in
      assign tap_re_d[i] = shift_en ? wr_re : tap_re_q[i];
      assign tap_im_d[i] = shift_en ? wr_im : tap_im_q[i];
    end else begin : g_chain
      assign tap_re_d[i] = shift_en ? tap_re_q[i-1] : tap_re_q[i];
      assign tap_im_d[i] = shift_en ? tap_im_q[i-1] : tap_im_q[i];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        tap_re_q[i] <= '0;
        tap_im_q[i] <= '0;
      end else begin
        tap_re_q[i] <= tap_re_d[i];
        tap_im_q[i] <= tap_im_d[i];
      end
    end
  end

  assign head_re = tap_re_q[DEPTH-1];
  assign head_im = tap_im_q[DEPTH-1];

  // R8: the line is empty in the first cycle after reset release
  p_reset_empty_r8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (head_re == '0) && (head_im == '0));
endmodule

// File: rtl/sdf_rot_bfly.sv
module sdf_rot_bfly
  import srb_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int DLY_LEN = 4,
  localparam int OUT_W  = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bf_sel,
  input  logic              rot_sel,
  input  logic [DATA_W-1:0] din_re,
  input  logic [DATA_W-1:0] din_im,
  output logic [OUT_W-1:0]  dout_re,
  output logic [OUT_W-1:0]  dout_im
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic             srst_n;
  srb_phase_e       phase;
  logic             rot_en;
  logic [OUT_W-1:0] xr_re;
  logic [OUT_W-1:0] xr_im;
  logic [OUT_W-1:0] head_re;
  logic [OUT_W-1:0] head_im;
  logic [OUT_W-1:0] fb_re;
  logic [OUT_W-1:0] fb_im;

  assign phase  = bf_sel ? PH_BFLY : PH_LOAD;
  assign rot_en = bf_sel & rot_sel;

  srb_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  srb_rotate #(.DATA_W(DATA_W)) u_rotate (
    .in_re  (din_re),
    .in_im  (din_im),
    .rot_en (rot_en),
    .out_re (xr_re),
    .out_im (xr_im)
  );

  srb_addsub #(.VAL_W(OUT_W)) u_addsub (
    .clk    (clk),
    .srst_n (srst_n),
    .phase  (phase),
    .old_re (head_re),
    .old_im (head_im),
    .new_re (xr_re),
    .new_im (xr_im),
    .out_re (dout_re),
    .out_im (dout_im),
    .fb_re  (fb_re),
    .fb_im  (fb_im)
  );

  srb_delay #(.VAL_W(OUT_W), .DEPTH(DLY_LEN)) u_delay (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_re   (fb_re),
    .wr_im   (fb_im),
    .head_re (head_re),
    .head_im (head_im)
  );

  // R3: rotated operand is (Im, -Re)
  p_rot_swap_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (bf_sel && rot_sel) |->
      (xr_re == {din_im[DATA_W-1], din_im}) &&
      ((xr_im + {din_re[DATA_W-1], din_re}) == '0));

  // R4: in the load phase the operand is the plain input
  p_load_unrot_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !bf_sel |-> (xr_re == {din_re[DATA_W-1], din_re}) &&
                (xr_im == {din_im[DATA_W-1], din_im}));

  // R5: negating the most negative real part gives a positive value
  p_min_neg_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (bf_sel && rot_sel && din_re == MOST_NEG) |-> !xr_im[OUT_W-1]);

  // R2: sum plus fed-back difference equals twice the stored value
  p_sum_dif_r2: assert property (@(posedge clk) disable iff (!srst_n)
    bf_sel |->
      (({dout_re[OUT_W-1], dout_re} + {fb_re[OUT_W-1], fb_re}) == {head_re, 1'b0}) &&
      (({dout_im[OUT_W-1], dout_im} + {fb_im[OUT_W-1], fb_im}) == {head_im, 1'b0}));
endmodule

// File: tb/sdf_rot_bfly_bench.sv
`timescale 1ns/1ps
module sdf_rot_bfly_bench;
  localparam int W    = 12;
  localparam int D    = 4;
  localparam int T    = 4000;
  localparam int VMIN = -(1 << (W - 1));
  localparam int VMAX = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic bf_sel;
  logic rot_sel;
  logic [W-1:0] din_re;
  logic [W-1:0] din_im;
  logic [W:0]   dout_re;
  logic [W:0]   dout_im;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int x_re  [0:4095];
  int x_im  [0:4095];
  int xr_re [0:4095];
  int xr_im [0:4095];
  bit rotld [0:4095];
  bit extr  [0:4095];

  always #4 clk = ~clk;

  sdf_rot_bfly #(.DATA_W(W), .DLY_LEN(D)) u_sdf_rot_bfly (
    .clk     (clk),
    .rst_n   (rst_n),
    .bf_sel  (bf_sel),
    .rot_sel (rot_sel),
    .din_re  (din_re),
    .din_im  (din_im),
    .dout_re (dout_re),
    .dout_im (dout_im)
  );

  function automatic int pick_val();
    int r;
    r = int'($urandom % 8);
    if (r == 0) return VMIN;
    if (r == 1) return VMAX;
    return int'($urandom % (1 << W)) - (1 << (W - 1));
  endfunction

  function automatic bit is_ext(int v);
    return (v == VMIN) || (v == VMAX);
  endfunction

  task automatic check(string tag, int exp_re, int exp_im);
    int act_re;
    int act_im;
    act_re = int'($signed(dout_re));
    act_im = int'($signed(dout_im));
    checks++;
    if (act_re != exp_re || act_im != exp_im) begin
      errors++;
      $display("FAIL %s actual (%0d,%0d) expected (%0d,%0d) at %0t",
               tag, act_re, act_im, exp_re, exp_im, $time);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; bf_sel = 1'b0; rot_sel = 1'b0; din_re = '0; din_im = '0;
    repeat (3) @(negedge clk);
    #1 check("R8 reset", 0, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int t = 0; t < T; t++) begin
      int ph;
      bit b;
      bit r;
      int er;
      int ei;
      string tag;
      ph = t % (4 * D);
      b  = ((t / D) % 2) == 1;
      if (b) r = (ph >= 3 * D);
      else   r = 1'($urandom % 2);
      // directed corners in the first outer frame
      if (t >= 2 * D && t < 3 * D) begin
        x_re[t] = VMAX; x_im[t] = VMAX;
      end else if (t >= 3 * D && t < 4 * D) begin
        x_re[t] = VMIN; x_im[t] = VMAX;
      end else begin
        x_re[t] = pick_val(); x_im[t] = pick_val();
      end
      rotld[t] = !b && r;
      extr[t]  = is_ext(x_re[t]) || is_ext(x_im[t]);
      if (b && r) begin
        xr_re[t] = x_im[t]; xr_im[t] = -x_re[t];
      end else begin
        xr_re[t] = x_re[t]; xr_im[t] = x_im[t];
      end
      bf_sel = b; rot_sel = r;
      din_re = W'(x_re[t]); din_im = W'(x_im[t]);
      #1;
      if (b) begin
        er = x_re[t-D] + xr_re[t];
        ei = x_im[t-D] + xr_im[t];
        if (r && x_re[t] == VMIN)        tag = "R5";
        else if (r)                      tag = "R3";
        else if (rotld[t-D])             tag = "R4";
        else if (t < 2 * D)              tag = "R7";
        else if (extr[t] || extr[t-D])   tag = "R6";
        else                             tag = "R2";
      end else if (t < D) begin
        er = 0; ei = 0; tag = "R8";
      end else begin
        er = x_re[t-2*D] - xr_re[t-D];
        ei = x_im[t-2*D] - xr_im[t-D];
        if (extr[t-D] || extr[t-2*D]) tag = "R6";
        else                          tag = "R1";
      end
      check(tag, er, ei);
      @(negedge clk);
    end
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule